// File: doc/BRIEF.md
# Transactional Cache Set Tracker

This block holds the tag array of a set-associative level-one data cache. For every line it keeps a valid mark, a dirty mark and two transactional marks: one for a speculative write and one for a speculative read. A single request port carries lookups, demand fills, retiring speculative loads, draining speculative stores, prefetch fills, and the commit and abort of a speculative region. Each request carries a set index and a tag. The block answers one cycle later with hit and way information, the victim it chose, a write-back request and a set-full flag.

Replacement protects transactional lines. A way with no transactional mark is always preferred, and an invalid way comes before any valid one. When a miss finds every way of the set marked, the block raises set-full instead of evicting anything. The load/store queue uses that flag to keep its entry, or to send the access around the cache. A prefetch that would need such an eviction is dropped. Commit makes speculatively written lines permanent as dirty lines. Abort removes them. Both operations clear every transactional mark in one cycle.

Top module: `txn_set_tracker`

## Requirements
- R1: Every request accepted with req_valid high produces rsp_valid high in the next cycle and in no other cycle. Operation codes on req_op are: 0 lookup, 1 demand fill, 2 load retire, 3 store drain, 4 prefetch fill, 5 commit, 6 abort. A lookup changes no state. On a hit it reports rsp_way and the line's dirty, speculative-write and speculative-read marks (rsp_dirty, rsp_sw, rsp_sr) as they stood before the request.
- R2: A load retire that hits sets the line's speculative-read mark. On a miss with a free candidate way, it installs the tag with only that mark set.
- R3: A store drain that hits sets the speculative-write and dirty marks together. On a miss with a free candidate way, it installs the tag with both of those marks set.
- R4: A store drain that hits a dirty line whose speculative-write mark is clear raises rsp_wb. A drain onto a line that already carries the speculative-write mark does not.
- R5: When a miss allocates, the lowest-numbered invalid way is the victim, and rsp_victim reports it. On a hit, or when the set is full, rsp_victim is 0.
- R6: When no way is invalid, a per-set round-robin pointer starts at 0 after reset. The victim is the first way at or after the pointer, wrapping around, that holds no transactional mark. The pointer then moves to the way after the victim. Allocation into an invalid way leaves the pointer where it is.
- R7: A way holding either transactional mark is never chosen while an unmarked way exists in the set. rsp_wb is raised when the evicted victim was valid and dirty.
- R8: A lookup, fill, load retire or store drain that misses in a set whose ways all carry a transactional mark raises rsp_set_full. It does not raise rsp_hit or rsp_wb, and it changes no line.
- R9: A prefetch fill that misses a full set is dropped: rsp_set_full is raised and a later lookup of its tag misses. A prefetch fill into a set with a free candidate way installs the line clean.
- R10: Commit clears every transactional mark in one cycle. Lines that had the speculative-write mark stay valid and dirty.
- R11: Abort invalidates every line holding the speculative-write mark and clears all speculative-read marks. Lines that only had the read mark stay valid.
- R12: After reset every line is invalid, every pointer is 0 and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R1) |
| req_set | input | SET_W | Set index |
| req_tag | input | TAG_W | Tag |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | Tag was present and valid |
| rsp_way | output | WAY_W | Hit way |
| rsp_victim | output | WAY_W | Chosen victim on an allocating miss |
| rsp_wb | output | 1 | The line must be written back first |
| rsp_set_full | output | 1 | Miss in a set whose ways all carry transactional marks |
| rsp_dirty | output | 1 | Dirty mark of the hit line |
| rsp_sw | output | 1 | Speculative-write mark of the hit line |
| rsp_sr | output | 1 | Speculative-read mark of the hit line |

## Verification
One set is stepped through a sequence of operations. Empty ways fill in index order, then the set is refilled with a mix of clean and transactional lines, so that invalid-first choice, rotation that skips marked ways, and the full condition each give a different victim. Lookups placed between the operations show each line's marks before and after commit and abort. They tell a line made permanent apart from a discarded one, and a dropped prefetch apart from an installed one. Store drains onto committed dirty lines and onto already-marked lines separate the two write-back cases, and a lookup in an untouched set shows that sets are kept apart.

// File: rtl/txn_set_pkg.sv
package txn_set_pkg;

  typedef enum logic [2:0] {
    OP_LOOKUP = 3'd0,
    OP_FILL   = 3'd1,
    OP_LDRET  = 3'd2,
    OP_DRAIN  = 3'd3,
    OP_PFILL  = 3'd4,
    OP_COMMIT = 3'd5,
    OP_ABORT  = 3'd6
  } op_e;

  typedef struct packed {
    logic valid;
    logic dirty;
    logic spec_wr;
    logic spec_rd;
  } line_flags_t;

endpackage

// File: rtl/txn_line_array.sv
module txn_line_array
  import txn_set_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic [SET_W-1:0]  rd_set,
  output logic [TAG_W-1:0]  rd_tags  [WAYS],
  output line_flags_t       rd_flags [WAYS],
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  line_flags_t       wr_flags,
  input  logic              commit_en,
  input  logic              abort_en,
  output logic              spec_any
);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  line_flags_t      flg_q [SETS][WAYS];
  line_flags_t      flg_d [SETS][WAYS];

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        flg_d[s][w] = flg_q[s][w];
        if (commit_en) begin
          flg_d[s][w].dirty   = flg_q[s][w].dirty | flg_q[s][w].spec_wr;
          flg_d[s][w].spec_wr = 1'b0;
          flg_d[s][w].spec_rd = 1'b0;
        end else if (abort_en) begin
          if (flg_q[s][w].spec_wr) begin
            flg_d[s][w] = '0;
          end else begin
            flg_d[s][w].spec_rd = 1'b0;
          end
        end else if (wr_en && (SET_W'(s) == wr_set) && (WAY_W'(w) == wr_way)) begin
          flg_d[s][w] = wr_flags;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          flg_q[s][w] <= '0;
        end
      end
    end else begin
      flg_q <= flg_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_tags[w]  = tag_q[rd_set][w];
      rd_flags[w] = flg_q[rd_set][w];
    end
  end

  always_comb begin
    spec_any = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        spec_any = spec_any | flg_q[s][w].spec_wr | flg_q[s][w].spec_rd;
      end
    end
  end

endmodule

// File: rtl/txn_hit_detect.sv
module txn_hit_detect
  import txn_set_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0] tags  [WAYS],
  input  line_flags_t      flags [WAYS],
  input  logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way
);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = flags[w].valid && (tags[w] == tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/txn_victim_pick.sv
module txn_victim_pick
  import txn_set_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  line_flags_t      flags [WAYS],
  input  logic [WAY_W-1:0] ptr,
  output logic             found,
  output logic             from_invalid,
  output logic [WAY_W-1:0] victim
);

  logic [WAYS-1:0] cand;
  logic [WAYS-1:0] empty;

  for (genvar w = 0; w < WAYS; w++) begin : g_mark
    assign cand[w]  = !(flags[w].spec_wr || flags[w].spec_rd);
    assign empty[w] = !flags[w].valid;
  end

  logic [WAY_W-1:0] inv_way;
  logic [WAY_W-1:0] rr_way;
  logic             rr_found;

  always_comb begin
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (empty[w]) inv_way = WAY_W'(w);
    end
  end

  always_comb begin
    rr_way   = '0;
    rr_found = 1'b0;
    for (int k = 0; k < WAYS; k++) begin
      if (!rr_found && cand[WAY_W'((int'(ptr) + k) % WAYS)]) begin
        rr_way   = WAY_W'((int'(ptr) + k) % WAYS);
        rr_found = 1'b1;
      end
    end
  end

  assign from_invalid = |empty;
  assign found        = rr_found;
  assign victim       = from_invalid ? inv_way : rr_way;

endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
  import txn_set_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic [WAY_W-1:0] rsp_victim,
  output logic             rsp_wb,
  output logic             rsp_set_full,
  output logic             rsp_dirty,
  output logic             rsp_sw,
  output logic             rsp_sr
);

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [TAG_W-1:0] rd_tags  [WAYS];
  line_flags_t      rd_flags [WAYS];
  logic             wr_en, commit_en, abort_en, spec_any;
  logic [WAY_W-1:0] wr_way;
  line_flags_t      wr_flags;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             found, from_invalid;
  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] ptr_q [SETS];
  logic [WAY_W-1:0] ptr_d;
  logic             ptr_we;

  txn_line_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_array (
    .clk       (clk),
    .rst_i     (rst_i),
    .rd_set    (req_set),
    .rd_tags   (rd_tags),
    .rd_flags  (rd_flags),
    .wr_en     (wr_en),
    .wr_set    (req_set),
    .wr_way    (wr_way),
    .wr_tag    (req_tag),
    .wr_flags  (wr_flags),
    .commit_en (commit_en),
    .abort_en  (abort_en),
    .spec_any  (spec_any)
  );

  txn_hit_detect #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
    .tags    (rd_tags),
    .flags   (rd_flags),
    .tag     (req_tag),
    .hit     (hit),
    .hit_way (hit_way)
  );

  txn_victim_pick #(.WAYS(WAYS)) u_pick (
    .flags        (rd_flags),
    .ptr          (ptr_q[req_set]),
    .found        (found),
    .from_invalid (from_invalid),
    .victim       (victim)
  );

  op_e         op;
  line_flags_t hit_flags, vic_flags;
  logic        hit_d, wb_d, full_d, valid_d;
  logic [WAY_W-1:0] way_d, vic_d;
  line_flags_t rep_d;

  assign op        = op_e'(req_op);
  assign hit_flags = rd_flags[hit_way];
  assign vic_flags = rd_flags[victim];

  always_comb begin
    valid_d   = req_valid;
    hit_d     = 1'b0;
    wb_d      = 1'b0;
    full_d    = 1'b0;
    way_d     = '0;
    vic_d     = '0;
    rep_d     = '0;
    wr_en     = 1'b0;
    wr_way    = hit_way;
    wr_flags  = hit_flags;
    commit_en = 1'b0;
    abort_en  = 1'b0;
    ptr_we    = 1'b0;
    ptr_d     = victim + WAY_W'(1);
    if (req_valid) begin
      case (op)
        OP_COMMIT: commit_en = 1'b1;
        OP_ABORT:  abort_en  = 1'b1;
        OP_LOOKUP, OP_FILL, OP_LDRET, OP_DRAIN, OP_PFILL: begin
          if (hit) begin
            hit_d = 1'b1;
            way_d = hit_way;
            rep_d = hit_flags;
            if (op == OP_LDRET) begin
              wr_en            = 1'b1;
              wr_flags.spec_rd = 1'b1;
            end else if (op == OP_DRAIN) begin
              wr_en            = 1'b1;
              wr_flags.spec_wr = 1'b1;
              wr_flags.dirty   = 1'b1;
              wb_d             = hit_flags.dirty && !hit_flags.spec_wr;
            end
          end else if (!found) begin
            full_d = 1'b1;
          end else if (op != OP_LOOKUP) begin
            vic_d            = victim;
            wb_d             = vic_flags.valid && vic_flags.dirty;
            wr_en            = 1'b1;
            wr_way           = victim;
            wr_flags.valid   = 1'b1;
            wr_flags.spec_rd = (op == OP_LDRET);
            wr_flags.spec_wr = (op == OP_DRAIN);
            wr_flags.dirty   = (op == OP_DRAIN);
            ptr_we           = !from_invalid;
          end else begin
            vic_d = victim;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (ptr_we) begin
      ptr_q[req_set] <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= '0;
      rsp_victim   <= '0;
      rsp_wb       <= 1'b0;
      rsp_set_full <= 1'b0;
      rsp_dirty    <= 1'b0;
      rsp_sw       <= 1'b0;
      rsp_sr       <= 1'b0;
    end else begin
      rsp_valid    <= valid_d;
      rsp_hit      <= hit_d;
      rsp_way      <= way_d;
      rsp_victim   <= vic_d;
      rsp_wb       <= wb_d;
      rsp_set_full <= full_d;
      rsp_dirty    <= rep_d.dirty;
      rsp_sw       <= rep_d.spec_wr;
      rsp_sr       <= rep_d.spec_rd;
    end
  end

endmodule

// File: rtl/txn_set_tracker_chk.sv
module txn_set_tracker_chk
  import txn_set_pkg::*;
(
  input logic       clk,
  input logic       rst_i,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic       rsp_wb,
  input logic       rsp_set_full,
  input logic       spec_any
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_i)
    rsp_valid |-> $past(req_valid)); // R1

  AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_i)
    $past(req_valid) |-> rsp_valid); // R1

  AST_HIT_WB_FROM_DRAIN: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_valid && rsp_hit && rsp_wb) |-> ($past(req_op) == 3'(OP_DRAIN))); // R4

  AST_FULL_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_i)
    rsp_set_full |-> (!rsp_hit && !rsp_wb)); // R8

  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_i)
    $past(req_valid && (req_op == 3'(OP_COMMIT))) |-> !spec_any); // R10

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_i)
    $past(req_valid && (req_op == 3'(OP_ABORT))) |-> !spec_any); // R11

endmodule

bind txn_set_tracker txn_set_tracker_chk u_chk (
  .clk          (clk),
  .rst_i        (rst_i),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_wb       (rsp_wb),
  .rsp_set_full (rsp_set_full),
  .spec_any     (spec_any)
);

// File: tb/txn_set_tracker_tb.sv
module txn_set_tracker_tb;

  localparam int SETS = 8, WAYS = 4, TAG_W = 8;
  localparam int NVEC = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [2:0] req_set = 3'd0;
  logic [7:0] req_tag = 8'd0;
  logic rsp_valid, rsp_hit, rsp_wb, rsp_set_full, rsp_dirty, rsp_sw, rsp_sr;
  logic [1:0] rsp_way, rsp_victim;

  always #5 clk = ~clk;

  txn_set_tracker #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_set(req_set), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_victim(rsp_victim),
    .rsp_wb(rsp_wb), .rsp_set_full(rsp_set_full), .rsp_dirty(rsp_dirty),
    .rsp_sw(rsp_sw), .rsp_sr(rsp_sr)
  );

  // op, set, tag, hit, way, victim, wb, full, dirty, sw, sr, requirement
  typedef struct packed {
    logic [2:0] op;
    logic [2:0] set;
    logic [7:0] tag;
    logic       hit;
    logic [1:0] way;
    logic [1:0] vic;
    logic       wb;
    logic       full;
    logic       d;
    logic       sw;
    logic       sr;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 3'd1, 8'h10, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 empty set
    '{3'd1, 3'd1, 8'h10, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd1, 3'd1, 8'h11, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
    '{3'd2, 3'd1, 8'h12, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 miss install
    '{3'd3, 3'd1, 8'h13, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 miss install
    '{3'd0, 3'd1, 8'h12, 1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // R2
    '{3'd0, 3'd1, 8'h13, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3},  // R3
    '{3'd1, 3'd1, 8'h14, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 ptr 0
    '{3'd1, 3'd1, 8'h15, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 ptr 1
    '{3'd1, 3'd1, 8'h16, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 skip marked
    '{3'd0, 3'd1, 8'h14, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 no change
    '{3'd2, 3'd1, 8'h16, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 hit
    '{3'd2, 3'd1, 8'h15, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 hit
    '{3'd1, 3'd1, 8'h17, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 fill full
    '{3'd4, 3'd1, 8'h18, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 drop
    '{3'd2, 3'd1, 8'h19, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 retire full
    '{3'd0, 3'd1, 8'h18, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 dropped
    '{3'd3, 3'd1, 8'h15, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 clean
    '{3'd5, 3'd0, 8'h00, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 commit
    '{3'd0, 3'd1, 8'h13, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
    '{3'd0, 3'd1, 8'h12, 1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{3'd3, 3'd1, 8'h13, 1'b1, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 wb
    '{3'd3, 3'd1, 8'h13, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 no wb
    '{3'd2, 3'd1, 8'h12, 1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd6, 3'd0, 8'h00, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 abort
    '{3'd0, 3'd1, 8'h13, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 gone
    '{3'd0, 3'd1, 8'h12, 1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 kept
    '{3'd1, 3'd1, 8'h1a, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 invalid way
    '{3'd1, 3'd1, 8'h1b, 1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 dirty evict
    '{3'd4, 3'd1, 8'h1c, 1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 install
    '{3'd0, 3'd1, 8'h1c, 1'b1, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
    '{3'd0, 3'd2, 8'h1b, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1}   // R1 other set
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string what, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", what, act, exp);
    end
  endtask

  function automatic logic [11:0] pack_rsp();
    return {rsp_valid, rsp_hit, rsp_way, rsp_victim, rsp_wb, rsp_set_full,
            rsp_dirty, rsp_sw, rsp_sr, 1'b0};
  endfunction

  task automatic issue(input logic [2:0] op, input logic [2:0] s, input logic [7:0] t);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_set   = s;
    req_tag   = t;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R12 reset outputs", pack_rsp(), 12'h000);

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i].op, VEC[i].set, VEC[i].tag);
      check($sformatf("R%0d vector %0d", VEC[i].rq, i), pack_rsp(),
            {1'b1, VEC[i].hit, VEC[i].way, VEC[i].vic, VEC[i].wb, VEC[i].full,
             VEC[i].d, VEC[i].sw, VEC[i].sr, 1'b0});
    end

    @(negedge clk);
    check("R1 no request no response", pack_rsp(), 12'h000);

    do_reset();
    issue(3'd0, 3'd1, 8'h1c);
    check("R12 lookup after reset misses", pack_rsp(), 12'h800);
    issue(3'd1, 3'd1, 8'h20);
    issue(3'd1, 3'd1, 8'h21);
    issue(3'd1, 3'd1, 8'h22);
    issue(3'd1, 3'd1, 8'h23);
    issue(3'd1, 3'd1, 8'h24);
    check("R12 pointer restarts at 0", pack_rsp(), {1'b1, 1'b0, 2'd0, 2'd0, 6'b0});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule